// File: doc/BRIEF.md
# SDRAM Command Guard

This block sits beside the command pins of a low-power single-data-rate SDRAM device model with four banks. It samples the chip-select, row-strobe, column-strobe and write-enable lines, the bank select and the 12-bit address bus on every rising clock. From these it works out which command was issued and keeps a copy of the programmed mode word. It also tracks which banks hold an open row and counts down the quiet period that follows a write with auto-precharge.

When a command arrives that the device may not take at that moment, the block refuses it. A refused command changes no state, and its reason is recorded as a 3-bit code that stays put until software-independent logic raises a synchronous clear. A verification environment or a device model uses the block to find controller sequences that break the device's timing and ordering rules. The write lockout lasts (burst length − 1) + `TWR` + `TRP` cycles, and `TWR` and `TRP` are parameters.

Top module: `sdram_cmd_guard`

## Requirements
- R1: While `rst` is high and on the first cycle after it drops, `viol_valid` is 0, `viol_code` is 0, `lock_count` is 0, `bank_open` is all zero and `mode_valid` is 0.
- R2: A mode-register write is decoded when chip select, row strobe, column strobe and write enable are all low. It is accepted when no bank is open and its fields are legal. On the next edge `mode_valid` becomes 1 and `mode_word` becomes {ba, addr}. The outputs then show the new fields: CAS latency from addr[6:4], addressing mode from addr[3], and burst length from addr[2:0] (codes 0,1,2,3 → 1,2,4,8 and code 7 → 256). `mode_valid` stays 1 until reset, and the command in the very next cycle is accepted.
- R3: A write is decoded when row strobe is high and column strobe and write enable are low. If addr[10] is high and the burst length is not 256, the write closes bank `ba` and loads `lock_count` with (burst length − 1) + TWR + TRP on the same edge. The count then drops by one per clock until it reaches 0.
- R4: While `lock_count` is nonzero, any command other than NOP (all three strobes high) or deselect records code 1 and has no effect on bank or mode state.
- R5: When the burst length is 256, a write with addr[10] high behaves as a plain write: `lock_count` stays 0 and the bank stays open.
- R6: An activate (row strobe low, others high) opens bank `ba`. A precharge (row strobe and write enable low, column strobe high) closes bank `ba` when addr[10] is low and closes every bank when addr[10] is high. A read (row strobe and write enable high, column strobe low) with addr[10] high closes bank `ba`.
- R7: A mode-register write while any bank is open records code 2 and leaves the mode register unchanged.
- R8: A read or write before the first accepted mode-register write records code 3 and has no effect.
- R9: A mode-register write whose CAS latency field is not 2 or 3, or whose burst code is 4, 5 or 6, records code 4 and is rejected.
- R10: With `cs_n` high the cycle is a deselect. It never records a violation and changes no state, including during a lockout.
- R11: The first violation code is held while `viol_clr` is low, and later violations do not overwrite it. When `viol_clr` is high, the register takes that cycle's violation code, which is 0 if the cycle has none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| ba | input | BANK_W (2) | Bank select |
| addr | input | ADDR_W (12) | Address bus; bit 10 selects auto-precharge / all banks |
| viol_clr | input | 1 | Synchronous clear of the violation register |
| viol_valid | output | 1 | A violation has been recorded |
| viol_code | output | 3 | 1 lockout, 2 mode write with bank open, 3 access before mode set, 4 illegal mode field |
| lock_count | output | LOCK_W (4) | Cycles left in the write auto-precharge lockout |
| bank_open | output | NBANK (4) | One bit per bank, 1 when a row is open |
| mode_valid | output | 1 | The mode register has been written |
| mode_word | output | BANK_W+ADDR_W (14) | Stored mode value {ba, addr} |
| mode_cl | output | 3 | Stored CAS latency |
| mode_bt | output | 1 | Stored addressing mode bit |
| mode_bl_len | output | 9 | Stored burst length in beats |

## Verification
The bench drives the lockout to its edges. It checks a command one cycle before the count reaches zero and one on the first free cycle. A design with an off-by-one lockout length would either flag the legal command or let the early one through. Commands sent during the lockout are shown to leave the bank bits untouched, and a deselect with noisy strobes is sent during it; a design that acted on refused commands or decoded strobes without chip select would corrupt `bank_open`. The full-page write, the mode writes with an open bank or a reserved field, and a clear issued in the same cycle as a fresh violation each catch a specific wrong priority.

// File: rtl/sdcg_pkg.sv
package sdcg_pkg;

    typedef enum logic [3:0] {
        OP_DESEL,
        OP_NOP,
        OP_MRS,
        OP_REF,
        OP_PRE,
        OP_ACT,
        OP_WR,
        OP_RD,
        OP_BST
    } op_e;

    typedef struct packed {
        op_e  op;
        logic ap;      // address bit that means auto-precharge / all banks
    } cmd_t;

    typedef enum logic [2:0] {
        VC_NONE       = 3'd0,
        VC_LOCK       = 3'd1,
        VC_MRS_OPEN   = 3'd2,
        VC_EARLY      = 3'd3,
        VC_MODE_FIELD = 3'd4
    } viol_e;

    typedef struct packed {
        logic [2:0] cl;
        logic       bt;
        logic [2:0] blc;
    } mode_t;

    localparam logic [8:0] FULL_PAGE_LEN = 9'd256;

    function automatic mode_t mode_split(input logic [6:0] w);
        mode_t m;
        m.cl  = w[6:4];
        m.bt  = w[3];
        m.blc = w[2:0];
        return m;
    endfunction

    // Zero marks a reserved burst code.
    function automatic logic [8:0] burst_len(input logic [2:0] code);
        logic [8:0] len;
        case (code)
            3'd0:    len = 9'd1;
            3'd1:    len = 9'd2;
            3'd2:    len = 9'd4;
            3'd3:    len = 9'd8;
            3'd7:    len = FULL_PAGE_LEN;
            default: len = 9'd0;
        endcase
        return len;
    endfunction

    function automatic logic mode_legal(input logic [6:0] w);
        mode_t m;
        m = mode_split(w);
        return ((m.cl == 3'd2) || (m.cl == 3'd3)) && (burst_len(m.blc) != 9'd0);
    endfunction

endpackage

// File: rtl/sdcg_decode.sv
module sdcg_decode
    import sdcg_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic ap,
    output cmd_t cmd
);
    always_comb begin
        cmd.ap = ap;
        if (cs_n) begin
            cmd.op = OP_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b000:  cmd.op = OP_MRS;
                3'b001:  cmd.op = OP_REF;
                3'b010:  cmd.op = OP_PRE;
                3'b011:  cmd.op = OP_ACT;
                3'b100:  cmd.op = OP_WR;
                3'b101:  cmd.op = OP_RD;
                3'b110:  cmd.op = OP_BST;
                default: cmd.op = OP_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdcg_mode_reg.sv
module sdcg_mode_reg
    import sdcg_pkg::*;
#(
    parameter int WORD_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] word_in,
    output logic              valid,
    output logic [WORD_W-1:0] word_q,
    output mode_t             fields,
    output logic [8:0]        bl_len,
    output logic              full_page,
    output logic              cand_ok
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            word_q <= '0;
        end else if (wr_en) begin
            valid  <= 1'b1;
            word_q <= word_in;
        end
    end

    always_comb begin
        fields    = mode_split(word_q[6:0]);
        bl_len    = burst_len(fields.blc);
        full_page = (bl_len == FULL_PAGE_LEN);
        cand_ok   = mode_legal(word_in[6:0]);
    end
endmodule

// File: rtl/sdcg_bank_track.sv
module sdcg_bank_track #(
    parameter int NBANK  = 4,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic              clr_one,
    input  logic              clr_all,
    input  logic [BANK_W-1:0] sel,
    output logic [NBANK-1:0]  open_vec
);
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic open_q;
        logic hit;
        assign hit = (sel == BANK_W'(b));
        always_ff @(posedge clk) begin
            if (rst || clr_all) begin
                open_q <= 1'b0;
            end else if (hit && set_en) begin
                open_q <= 1'b1;
            end else if (hit && clr_one) begin
                open_q <= 1'b0;
            end
        end
        assign open_vec[b] = open_q;
    end
endmodule

// File: rtl/sdcg_lockout.sv
module sdcg_lockout #(
    parameter int LOCK_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LOCK_W-1:0] load_val,
    output logic [LOCK_W-1:0] count,
    output logic              busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign busy = (count != '0);
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
    import sdcg_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 12,
    parameter int AP_BIT = 10,
    parameter int TWR    = 2,
    parameter int TRP    = 3,
    parameter int LOCK_W = $clog2(8 + TWR + TRP)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cs_n,
    input  logic                     ras_n,
    input  logic                     cas_n,
    input  logic                     we_n,
    input  logic [BANK_W-1:0]        ba,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     viol_clr,
    output logic                     viol_valid,
    output logic [2:0]               viol_code,
    output logic [LOCK_W-1:0]        lock_count,
    output logic [NBANK-1:0]         bank_open,
    output logic                     mode_valid,
    output logic [BANK_W+ADDR_W-1:0] mode_word,
    output logic [2:0]               mode_cl,
    output logic                     mode_bt,
    output logic [8:0]               mode_bl_len
);
    localparam int WORD_W = BANK_W + ADDR_W;

    cmd_t              cmd;
    mode_t             fields;
    logic              full_page;
    logic              field_ok;
    logic              busy;
    logic              any_open;
    logic [LOCK_W-1:0] lock_val;
    viol_e             verdict;
    viol_e             viol_q;
    logic              do_mrs, do_act, do_close, do_close_all, do_lock;

    sdcg_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ap    (addr[AP_BIT]),
        .cmd   (cmd)
    );

    sdcg_mode_reg #(.WORD_W(WORD_W)) u_mode (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (do_mrs),
        .word_in   ({ba, addr}),
        .valid     (mode_valid),
        .word_q    (mode_word),
        .fields    (fields),
        .bl_len    (mode_bl_len),
        .full_page (full_page),
        .cand_ok   (field_ok)
    );

    sdcg_bank_track #(.NBANK(NBANK), .BANK_W(BANK_W)) u_banks (
        .clk      (clk),
        .rst      (rst),
        .set_en   (do_act),
        .clr_one  (do_close),
        .clr_all  (do_close_all),
        .sel      (ba),
        .open_vec (bank_open)
    );

    sdcg_lockout #(.LOCK_W(LOCK_W)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .load     (do_lock),
        .load_val (lock_val),
        .count    (lock_count),
        .busy     (busy)
    );

    assign any_open = |bank_open;
    // Burst length minus one, plus write recovery and precharge time.
    assign lock_val = LOCK_W'(mode_bl_len) + LOCK_W'(TWR + TRP - 1);

    // Legality arbitration: a lockout refuses everything, then per-command rules.
    always_comb begin
        verdict      = VC_NONE;
        do_mrs       = 1'b0;
        do_act       = 1'b0;
        do_close     = 1'b0;
        do_close_all = 1'b0;
        do_lock      = 1'b0;
        if (cmd.op != OP_DESEL && cmd.op != OP_NOP) begin
            if (busy) begin
                verdict = VC_LOCK;
            end else begin
                case (cmd.op)
                    OP_MRS: begin
                        if (any_open)       verdict = VC_MRS_OPEN;
                        else if (!field_ok) verdict = VC_MODE_FIELD;
                        else                do_mrs  = 1'b1;
                    end
                    OP_ACT: do_act = 1'b1;
                    OP_PRE: begin
                        if (cmd.ap) do_close_all = 1'b1;
                        else        do_close     = 1'b1;
                    end
                    OP_RD: begin
                        if (!mode_valid)  verdict  = VC_EARLY;
                        else if (cmd.ap)  do_close = 1'b1;
                    end
                    OP_WR: begin
                        if (!mode_valid) begin
                            verdict = VC_EARLY;
                        end else if (cmd.ap && !full_page) begin
                            do_close = 1'b1;
                            do_lock  = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_q <= VC_NONE;
        end else if (viol_clr || viol_q == VC_NONE) begin
            viol_q <= verdict;
        end
    end

    assign viol_valid = (viol_q != VC_NONE);
    assign viol_code  = viol_q;
    assign mode_cl    = fields.cl;
    assign mode_bt    = fields.bt;
endmodule

// File: rtl/sdcg_chk.sv
module sdcg_chk #(
    parameter int NBANK  = 4,
    parameter int LOCK_W = 4,
    parameter int WORD_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic              viol_clr,
    input logic              viol_valid,
    input logic [2:0]        viol_code,
    input logic [LOCK_W-1:0] lock_count,
    input logic [NBANK-1:0]  bank_open,
    input logic              mode_valid,
    input logic [WORD_W-1:0] mode_word,
    input logic [8:0]        mode_bl_len
);
    // R3
    lock_countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_count != '0) |=> (lock_count == $past(lock_count) - 1'b1));

    // R5
    full_page_no_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_count == '0 && mode_bl_len == 9'd256) |=> (lock_count == '0));

    // R2
    mode_stays_valid_chk: assert property (@(posedge clk) disable iff (rst)
        mode_valid |=> mode_valid);

    // R7
    mrs_bank_open_chk: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ras_n && !cas_n && !we_n && (bank_open != '0) &&
         (lock_count == '0) && (!viol_valid || viol_clr)) |=> (viol_code == 3'd2));

    // R8
    early_access_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_valid && !cs_n && ras_n && !cas_n && (lock_count == '0) &&
         (!viol_valid || viol_clr)) |=> (viol_code == 3'd3));

    // R10
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(bank_open) && $stable(mode_word)));

    // R11
    sticky_code_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_valid && !viol_clr) |=> (viol_valid && $stable(viol_code)));
endmodule

bind sdram_cmd_guard sdcg_chk #(
    .NBANK  (NBANK),
    .LOCK_W (LOCK_W),
    .WORD_W (BANK_W + ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .viol_clr    (viol_clr),
    .viol_valid  (viol_valid),
    .viol_code   (viol_code),
    .lock_count  (lock_count),
    .bank_open   (bank_open),
    .mode_valid  (mode_valid),
    .mode_word   (mode_word),
    .mode_bl_len (mode_bl_len)
);

// File: tb/sim_sdram_cmd_guard.sv
`timescale 1ns/1ps
module sim_sdram_cmd_guard;
    localparam int TWR = 2;
    localparam int TRP = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic        viol_clr = 1'b0;
    logic        viol_valid;
    logic [2:0]  viol_code;
    logic [3:0]  lock_count;
    logic [3:0]  bank_open;
    logic        mode_valid;
    logic [13:0] mode_word;
    logic [2:0]  mode_cl;
    logic        mode_bt;
    logic [8:0]  mode_bl_len;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    int          m_lock = 0;
    logic [3:0]  m_bank = '0;
    bit          m_mv = 0;
    logic [13:0] m_word = '0;
    int          m_vc = 0;

    always #2.5 clk = ~clk;

    sdram_cmd_guard #(.TWR(TWR), .TRP(TRP)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .viol_clr(viol_clr), .viol_valid(viol_valid),
        .viol_code(viol_code), .lock_count(lock_count), .bank_open(bank_open),
        .mode_valid(mode_valid), .mode_word(mode_word), .mode_cl(mode_cl),
        .mode_bt(mode_bt), .mode_bl_len(mode_bl_len)
    );

    function automatic int len_of(input logic [2:0] c);
        if (c == 3'd7) return 256;
        if (c <= 3'd3) return 1 << c;
        return 0;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "viol_valid", int'(viol_valid), int'(m_vc != 0));
        chk(tag, "viol_code", int'(viol_code), m_vc);
        chk(tag, "lock_count", int'(lock_count), m_lock);
        chk(tag, "bank_open", int'(bank_open), int'(m_bank));
        chk(tag, "mode_valid", int'(mode_valid), int'(m_mv));
        if (m_mv) begin
            chk(tag, "mode_word", int'(mode_word), int'(m_word));
            chk(tag, "mode_cl", int'(mode_cl), int'(m_word[6:4]));
            chk(tag, "mode_bt", int'(mode_bt), int'(m_word[3]));
            chk(tag, "mode_bl_len", int'(mode_bl_len), len_of(m_word[2:0]));
        end
    endtask

    task automatic model_edge();
        int  nv;
        int  nl;
        bit  quiet;
        quiet = cs_n || (ras_n && cas_n && we_n);
        nv = 0;
        nl = (m_lock > 0) ? m_lock - 1 : 0;
        if (!quiet) begin
            if (m_lock > 0) begin
                nv = 1;
            end else if (!ras_n && !cas_n && !we_n) begin
                if (m_bank != 0) nv = 2;
                else if (!((addr[6:4] == 3'd2 || addr[6:4] == 3'd3) && len_of(addr[2:0]) != 0)) nv = 4;
                else begin m_mv = 1; m_word = {ba, addr}; end
            end else if (!ras_n && cas_n && we_n) begin
                m_bank[ba] = 1'b1;
            end else if (!ras_n && cas_n && !we_n) begin
                if (addr[10]) m_bank = '0;
                else m_bank[ba] = 1'b0;
            end else if (ras_n && !cas_n) begin
                if (!m_mv) nv = 3;
                else if (addr[10]) begin
                    if (we_n) m_bank[ba] = 1'b0;
                    else if (len_of(m_word[2:0]) != 256) begin
                        m_bank[ba] = 1'b0;
                        nl = len_of(m_word[2:0]) - 1 + TWR + TRP;
                    end
                end
            end
        end
        m_lock = nl;
        if (viol_clr) m_vc = nv;
        else if (m_vc == 0) m_vc = nv;
    endtask

    task automatic step(input string tag, input logic c, input logic r, input logic ca,
                        input logic w, input logic [1:0] b, input logic [11:0] a, input logic clr);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a; viol_clr = clr;
        @(posedge clk);
        model_edge();
        #1;
        compare_all(tag);
    endtask

    task automatic nop(input string tag);            step(tag, 0, 1, 1, 1, 2'd0, 12'h000, 0); endtask
    task automatic clear(input string tag);          step(tag, 0, 1, 1, 1, 2'd0, 12'h000, 1); endtask
    task automatic act(input string tag, input int b); step(tag, 0, 0, 1, 1, 2'(b), 12'h123, 0); endtask
    task automatic pre(input string tag, input int b, input bit all);
        step(tag, 0, 0, 1, 0, 2'(b), all ? 12'h400 : 12'h000, 0);
    endtask
    task automatic wr(input string tag, input int b, input bit ap);
        step(tag, 0, 1, 0, 0, 2'(b), ap ? 12'h455 : 12'h055, 0);
    endtask
    task automatic rd(input string tag, input int b, input bit ap);
        step(tag, 0, 1, 0, 1, 2'(b), ap ? 12'h4AA : 12'h0AA, 0);
    endtask
    task automatic mrs(input string tag, input int cl, input bit bt, input int blc, input bit clr);
        step(tag, 0, 0, 0, 0, 2'd1, {5'b0, 3'(cl), bt, 3'(blc)}, clr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1");
        rst = 1'b0;
        cs_n = 1'b0;
        @(posedge clk); #1;
        compare_all("R1");

        // R8: accesses before any mode set
        wr("R8", 0, 0);
        clear("R8");
        rd("R8", 2, 1);
        clear("R8");

        // R9: bad CAS latency, then reserved burst code
        mrs("R9", 1, 0, 0, 0);
        clear("R9");
        mrs("R9", 3, 0, 5, 0);
        clear("R9");

        // R7: mode write with a bank open
        act("R7", 1);
        mrs("R7", 2, 0, 1, 0);
        clear("R7");
        pre("R6", 0, 1);

        // R2: accepted mode write, command right after
        mrs("R2", 3, 1, 1, 0);
        act("R2", 2);

        // R3/R4/R10: lockout of 1+2+3 = 6 cycles
        wr("R3", 2, 1);
        step("R10", 1, 0, 0, 0, 2'd3, 12'hFFF, 0);
        nop("R3");
        act("R4", 0);
        nop("R3");
        nop("R3");
        act("R4", 3);   // last locked cycle
        act("R4", 3);   // first free cycle
        clear("R11");

        // R6: bank state tracking
        act("R6", 0);
        act("R6", 1);
        pre("R6", 1, 0);
        rd("R6", 3, 1);
        rd("R6", 0, 0);
        pre("R6", 0, 1);

        // R3: burst of 8 -> 12-cycle lockout
        mrs("R3", 2, 0, 3, 0);
        act("R3", 0);
        wr("R3", 0, 1);
        for (int i = 0; i < 12; i++) nop("R3");
        act("R3", 1);
        pre("R3", 0, 1);

        // R5: full page
        mrs("R5", 2, 0, 7, 0);
        act("R5", 1);
        wr("R5", 1, 1);
        act("R5", 2);
        pre("R5", 0, 1);

        // R11: sticky code, clear priority
        mrs("R11", 3, 0, 0, 0);
        act("R11", 0);
        wr("R11", 0, 1);
        act("R11", 1);
        pre("R11", 0, 1);
        for (int i = 0; i < 4; i++) nop("R11");
        act("R11", 1);
        mrs("R11", 2, 0, 2, 0);
        mrs("R11", 2, 0, 2, 1);
        clear("R11");
        nop("R11");
        step("R10", 1, 1, 0, 0, 2'd2, 12'h400, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule